// File: doc/BRIEF.md
# Ternary Entry Loader for an SRAM-Emulated TCAM Layer

This block writes ternary table entries into the two RAM structures that let plain SRAM stand in for a TCAM layer. The first is a one-bit-wide presence memory per partition. The second is a K-bit-wide membership table per partition, where bit j of a row stands for original entry address j. The block takes one entry at a time over a valid/ready handshake. An entry is a subword value with a care mask, a partition index and an original address. RAM cannot hold a don't-care, so the loader visits every binary row that the entry covers, in ascending order. For each row it sets the presence bit to 1. It also ORs the entry's one-hot bit into the membership row, so other entries already recorded in that row are kept.

The RAMs sit outside the block. The loader drives a shared partition/row address, a synchronous read strobe for the membership table, and write strobes and data for both memories. The read data must come back on the cycle after the strobe. A clear request sweeps every row of every partition and writes zeros. This brings all unprogrammed locations to 0 before a table is built. Entries that name a partition or an original address beyond the configured range are refused and flagged. Nothing is written for them.

Top module: `ternary_prog_engine`

## Requirements
- R1: `in_ready` is 1 exactly when the loader is idle. An entry or a clear is taken on a rising edge where `in_ready` is 1 and `in_valid` or `clr_valid` is 1.
- R2: For an accepted entry with care mask C (bit 1 = must match) and value V, the rows written are exactly every row r with (r & C) == (V & C). Value bits where C is 0 have no effect. There are 2^d rows for d zero bits in C. They are written in ascending numeric order, and each writes presence bit 1 in the named partition.
- R3: Each membership write stores the row read just before it, ORed with a one-hot of the original address (bit `in_addr` set). Bits already set for other entries are kept.
- R4: Each covered row takes two cycles: a read cycle with `oat_re`=1, then a write cycle with `vm_we` and `oat_we` both 1 at the same row. `in_ready` stays low for exactly 2·2^d cycles after acceptance.
- R5: A clear writes presence 0 and membership 0 to all 2^W rows of all N partitions, one row per cycle. `in_ready` stays low for exactly N·2^W cycles.
- R6: When `clr_valid` and `in_valid` are both 1 on an accepting edge, the clear is taken and the entry is dropped.
- R7: An entry with `in_addr` ≥ K is refused. `err` is 1 for the one cycle after that edge, no RAM strobe is issued, and `in_ready` stays 1.
- R8: An entry with `in_part` ≥ N is refused in the same way as R7.
- R9: After reset and whenever idle, no RAM strobe is active and `err` is 0 unless R7/R8 apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Entry request |
| in_value | input | W | Subword value |
| in_care | input | W | Care mask, 1 = bit must match |
| in_part | input | PW | Partition index |
| in_addr | input | AW | Original entry address |
| clr_valid | input | 1 | Clear-all request |
| in_ready | output | 1 | Loader idle, request may be taken |
| err | output | 1 | Refused entry, one-cycle pulse |
| mem_part | output | PW | Partition addressed by the RAM strobes |
| mem_row | output | W | Row addressed by the RAM strobes |
| vm_we | output | 1 | Presence memory write strobe |
| vm_wbit | output | 1 | Presence bit to write |
| oat_re | output | 1 | Membership table read strobe |
| oat_rdata | input | K | Membership row, valid the cycle after `oat_re` |
| oat_we | output | 1 | Membership table write strobe |
| oat_wdata | output | K | Membership row to write |

## Verification
The bench models both RAMs itself and preloads them with ones, so a clear that misses any row or partition shows up as leftover data. Entries are tried with no don't-cares, one, several scattered, and all bits free. These separate a wrong expansion count, a wrong bit deposit and a broken ascending order, and a row list computed independently is compared after each entry. Two entries with different addresses that cover a shared row show whether the membership write merges or overwrites. The refusal cases, the clear-versus-entry collision, and an entry with junk in its don't-care value bits check the handshake and masking rules at the ports.

// File: rtl/ternary_prog_engine.sv
module ternary_prog_engine #(
  parameter int W = 4,
  parameter int N = 3,
  parameter int K = 5,
  localparam int PW = (N > 1) ? $clog2(N) + 1 : 1,
  localparam int AW = (K > 1) ? $clog2(K) + 1 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_value,
  input  logic [W-1:0]  in_care,
  input  logic [PW-1:0] in_part,
  input  logic [AW-1:0] in_addr,
  input  logic          clr_valid,
  output logic          in_ready,
  output logic          err,
  output logic [PW-1:0] mem_part,
  output logic [W-1:0]  mem_row,
  output logic          vm_we,
  output logic          vm_wbit,
  output logic          oat_re,
  input  logic [K-1:0]  oat_rdata,
  output logic          oat_we,
  output logic [K-1:0]  oat_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_CLR} st_t;

  st_t           st;
  logic [W-1:0]  fixed_q, free_q, sub_q;
  logic [PW-1:0] part_q;
  logic [AW-1:0] addr_q;
  logic          err_q;

  wire          bad   = (32'(in_part) >= N) || (32'(in_addr) >= K);
  wire          last  = (sub_q == free_q);
  wire [W-1:0]  nxt   = (sub_q - free_q) & free_q;
  wire [K-1:0]  ohot  = K'(1) << addr_q;
  wire          lastp = (32'(part_q) == N - 1);

  assign in_ready  = (st == S_IDLE);
  assign oat_re    = (st == S_RD);
  assign vm_we     = (st == S_WR) || (st == S_CLR);
  assign oat_we    = vm_we;
  assign vm_wbit   = (st == S_WR);
  assign oat_wdata = (st == S_WR) ? (oat_rdata | ohot) : '0;
  assign mem_part  = part_q;
  assign mem_row   = fixed_q | sub_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fixed_q <= '0;
      free_q  <= '0;
      sub_q   <= '0;
      part_q  <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (clr_valid) begin
            st      <= S_CLR;
            fixed_q <= '0;
            free_q  <= '1;
            sub_q   <= '0;
            part_q  <= '0;
          end else if (in_valid) begin
            if (bad) begin
              err_q <= 1'b1;
            end else begin
              st      <= S_RD;
              fixed_q <= in_value & in_care;
              free_q  <= ~in_care;
              sub_q   <= '0;
              part_q  <= in_part;
              addr_q  <= in_addr;
            end
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          if (last) st <= S_IDLE;
          else begin
            sub_q <= nxt;
            st    <= S_RD;
          end
        end
        S_CLR: begin
          sub_q <= nxt;
          if (last) begin
            if (lastp) st <= S_IDLE;
            else part_q <= part_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ternary_prog_engine_chk.sv
module ternary_prog_engine_chk #(
  parameter int W = 4,
  parameter int K = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         err,
  input logic [W-1:0] mem_row,
  input logic         vm_we,
  input logic         vm_wbit,
  input logic         oat_re,
  input logic [K-1:0] oat_rdata,
  input logic         oat_we,
  input logic [K-1:0] oat_wdata
);

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    oat_re |=> (oat_we && vm_we && vm_wbit && $stable(mem_row))); // R4

  AST_SET_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_we && vm_wbit) |-> $past(oat_re)); // R4

  AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (oat_we && vm_wbit) |-> (((oat_wdata & oat_rdata) == oat_rdata) &&
                             ($countones(oat_wdata ^ oat_rdata) <= 1))); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_we && !vm_wbit) |-> (oat_we && (oat_wdata == '0))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!vm_we && !oat_we && !oat_re)); // R9

  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (in_ready && $past(in_ready))); // R7

endmodule

bind ternary_prog_engine ternary_prog_engine_chk #(.W(W), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .err(err),
  .mem_row(mem_row), .vm_we(vm_we), .vm_wbit(vm_wbit), .oat_re(oat_re),
  .oat_rdata(oat_rdata), .oat_we(oat_we), .oat_wdata(oat_wdata)
);

// File: tb/test_ternary_prog_engine.sv
module test_ternary_prog_engine;
  localparam int W = 4, N = 3, K = 5;
  localparam int PW = $clog2(N) + 1, AW = $clog2(K) + 1, R = 1 << W;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, clr_valid = 0;
  logic [W-1:0] in_value = '0, in_care = '0;
  logic [PW-1:0] in_part = '0;
  logic [AW-1:0] in_addr = '0;
  logic in_ready, err, vm_we, vm_wbit, oat_re, oat_we;
  logic [PW-1:0] mem_part;
  logic [W-1:0] mem_row;
  logic [K-1:0] oat_rdata, oat_wdata;

  int tests = 0, fails = 0;
  int busy = 0;
  logic exp_err = 0;
  logic vm_m [N][R];
  logic [K-1:0] oat_m [N][R];
  logic exp_vm [N][R];
  logic [K-1:0] exp_oat [N][R];
  int wr_rows[$];

  always #10 clk = ~clk;

  ternary_prog_engine #(.W(W), .N(N), .K(K)) i_ternary_prog_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_care(in_care), .in_part(in_part), .in_addr(in_addr),
    .clr_valid(clr_valid), .in_ready(in_ready), .err(err),
    .mem_part(mem_part), .mem_row(mem_row), .vm_we(vm_we), .vm_wbit(vm_wbit),
    .oat_re(oat_re), .oat_rdata(oat_rdata), .oat_we(oat_we), .oat_wdata(oat_wdata));

  // behavioural RAMs with synchronous read
  always @(posedge clk) begin
    if (oat_re && int'(mem_part) < N) oat_rdata <= oat_m[mem_part][mem_row];
    if (vm_we && int'(mem_part) < N) vm_m[mem_part][mem_row] <= vm_wbit;
    if (oat_we && int'(mem_part) < N) oat_m[mem_part][mem_row] <= oat_wdata;
    if (vm_we && vm_wbit) wr_rows.push_back(int'(mem_row));
  end

  // cycle model of handshake timing
  always @(posedge clk) begin
    exp_err <= 0;
    if (!rst_n) busy <= 0;
    else if (busy > 0) busy <= busy - 1;
    else if (clr_valid) busy <= N * R;
    else if (in_valid) begin
      if (int'(in_part) >= N || int'(in_addr) >= K) exp_err <= 1;
      else busy <= 2 * (1 << $countones(~in_care));
    end
  end

  always @(negedge clk) if (rst_n) begin
    tests++;
    if (in_ready !== (busy == 0)) begin
      fails++;
      $display("FAIL R4/R5 ready: got %b exp %b at %0t", in_ready, busy == 0, $time);
    end
    tests++;
    if (err !== exp_err) begin
      fails++;
      $display("FAIL R7/R8 err: got %b exp %b at %0t", err, exp_err, $time);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, act, expv);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int p = 0; p < N; p++)
      for (int r = 0; r < R; r++)
        if (vm_m[p][r] !== exp_vm[p][r] || oat_m[p][r] !== exp_oat[p][r]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic do_clear();
    wr_rows.delete();
    clr_valid = 1;
    @(negedge clk);
    clr_valid = 0;
    wait_idle();
    for (int p = 0; p < N; p++)
      for (int r = 0; r < R; r++) begin exp_vm[p][r] = 0; exp_oat[p][r] = '0; end
    cmp_mem("R5 clear");
  endtask

  task automatic entry(input logic [W-1:0] v, input logic [W-1:0] c,
                       input int p, input int a, input string req);
    int exp_rows[$];
    bit good;
    wr_rows.delete();
    in_valid = 1; in_value = v; in_care = c;
    in_part = PW'(p); in_addr = AW'(a);
    @(negedge clk);
    in_valid = 0;
    wait_idle();
    good = (p < N) && (a < K);
    if (good)
      for (int r = 0; r < R; r++)
        if ((W'(r) & c) == (v & c)) begin
          exp_rows.push_back(r);
          exp_vm[p][r] = 1;
          exp_oat[p][r][a] = 1'b1;
        end
    check(wr_rows.size() == exp_rows.size(), {req, " row count"}, wr_rows.size(), exp_rows.size());
    if (wr_rows.size() == exp_rows.size())
      foreach (exp_rows[i]) check(wr_rows[i] == exp_rows[i], {req, " row order"}, wr_rows[i], exp_rows[i]);
    cmp_mem({req, " memory"});
  endtask

  initial begin
    for (int p = 0; p < N; p++)
      for (int r = 0; r < R; r++) begin vm_m[p][r] = 1; oat_m[p][r] = '1; end
    oat_rdata = '0;
    repeat (3) @(negedge clk);
    check(in_ready === 1, "R1 reset ready", in_ready, 1);
    check(err === 0, "R9 reset err", err, 0);
    check(!vm_we && !oat_we && !oat_re, "R9 reset strobes", vm_we, 0);
    rst_n = 1;
    @(negedge clk);
    do_clear();                                   // R5
    entry(4'b0110, 4'b1111, 0, 0, "R2 exact");
    entry(4'b0100, 4'b1100, 0, 2, "R3 merge");
    entry(4'b0100, 4'b0101, 1, 4, "R2 scattered");
    entry(4'b0000, 4'b0000, 2, 1, "R2 all free");
    entry(4'b0111, 4'b0111, 2, 3, "R3 merge all-free");
    entry(4'b0001, 4'b1111, 0, 5, "R7 bad addr");
    entry(4'b0001, 4'b1111, 3, 0, "R8 bad part");
    wr_rows.delete();                             // R6 collision
    clr_valid = 1; in_valid = 1; in_value = 4'b1010; in_care = 4'b1111;
    in_part = 0; in_addr = 1;
    @(negedge clk);
    clr_valid = 0; in_valid = 0;
    wait_idle();
    for (int p = 0; p < N; p++)
      for (int r = 0; r < R; r++) begin exp_vm[p][r] = 0; exp_oat[p][r] = '0; end
    check(wr_rows.size() == 0, "R6 entry dropped", wr_rows.size(), 0);
    cmp_mem("R6 clear wins");
    entry(4'b1111, 4'b0011, 1, 0, "R2 junk in free bits");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule